// File: doc/BRIEF.md
# NAND Flash Target Page-Register Model

This block stands in for an 8-bit NAND flash device on the far side of a host controller under test. It watches the chip-enable, command-latch, address-latch, write-strobe and read-strobe lines and samples them on a fast system clock. From these it rebuilds the device's own command and address sequencer. A byte on the bus is taken on a rising write strobe. It becomes a command when the command latch line is high and an address byte when the address latch line is high. Otherwise it is page data.

The model keeps a page register of main plus spare bytes and a column counter that advances on every falling read strobe. It also holds a small cell array of a few blocks. It answers page read, page program, block erase, column redirection within the loaded page, status polling and reset. Each operation holds a ready/busy output low for a parameterised number of cycles. The model also copies two device limits. A page may be programmed at most four times between erases, and a block carrying a non-FFh marker in the first spare byte of its first page refuses programming and erasure.

Top module: `nand_target_model`

## Requirements
- R1: A bus byte is captured on the cycle a rising write strobe is seen with chip enable low. Command latch high (address latch low) marks a command, address latch high (command latch low) marks an address byte, and both low marks a data byte. With chip enable high no byte is taken, so a reset command then starts no busy period.
- R2: Read is command 00h, then five address bytes, then 30h. The address bytes are column low, column high, then three row bytes. Within the row, page occupies the low log2(PAGES_PER_BLOCK) bits and block the next log2(NUM_BLOCKS) bits. After T_READ busy cycles the page register holds the page. Each falling read strobe drives the byte at the current column and then advances the column.
- R3: The column never goes past the last column (MAIN_BYTES+SPARE_BYTES-1). Further read strobes there repeat the last byte.
- R4: Command 05h, two column bytes, then E0h moves the column counter. Later read strobes continue from the new column. This may be repeated any number of times.
- R5: Program is command 80h, five address bytes, optional data bytes written at the advancing column, and 10h. Command 85h plus two column bytes moves the load column. On 10h each cell of the page becomes old AND register, so bytes not loaded keep the register's earlier contents. Busy lasts T_PROG cycles.
- R6: A 10h that does not follow an 80h address sequence is ignored and starts no busy period.
- R7: Erase is command 60h, three row bytes, then D0h. It sets every byte of the block to FFh, clears the block's program counts and is busy for T_ERASE cycles.
- R8: A fifth program of one page since its last erase is refused. The cells keep their value and the fail bit is set.
- R9: If byte MAIN_BYTES of page 0 of a block (the first spare byte) is not FFh, program and erase of that block are refused and the fail bit is set.
- R10: After command 70h, the next falling read strobe returns status 0x40 when ready and 0x00 when busy, with bit 0 set for a failed last program or erase. 70h is accepted while busy.
- R11: The ready/busy output stays low for exactly the operation's cycle count. Raising chip enable during busy neither shortens nor ends it.
- R12: Command FFh is accepted in any state. It clears the fail bit, returns the sequencer to idle and is busy for T_RESET cycles.
- R13: After reset the model is ready, is not driving the bus, and every cell reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| we_ni | input | 1 | Write strobe, active low |
| re_ni | input | 1 | Read strobe, active low |
| dq_i | input | 8 | Bus byte from host |
| dq_o | output | 8 | Bus byte to host |
| dq_oe_o | output | 1 | Bus drive enable |
| rb_o | output | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the model with 16 main and 4 spare bytes per page, four pages per block and four blocks. Busy times are 3, 6, 9 and 5 cycles for read, program, erase and reset. The 20-byte page puts the last column and the spare marker a few strobes away from column zero. The short busy times let the bench count each busy period exactly and still issue a status poll inside an erase. Four blocks are enough to mark one bad while others remain usable.

// File: rtl/nand_tgt_pkg.sv
package nand_tgt_pkg;
  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_READ_GO  = 8'h30;
  localparam logic [7:0] CMD_RCOL     = 8'h05;
  localparam logic [7:0] CMD_RCOL_GO  = 8'hE0;
  localparam logic [7:0] CMD_LOAD     = 8'h80;
  localparam logic [7:0] CMD_LOAD_COL = 8'h85;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ADDR, ST_RC_ADDR, ST_PG_ADDR, ST_PG_DATA, ST_RI_ADDR, ST_ER_ADDR
  } seq_e;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} arr_op_e;
endpackage

// File: rtl/nand_strobe_decode.sv
module nand_strobe_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic cle_i,
  input  logic ale_i,
  input  logic we_ni,
  input  logic re_ni,
  output logic cmd_stb_o,
  output logic addr_stb_o,
  output logic data_stb_o,
  output logic rd_stb_o
);
  logic we_q, re_q, we_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      re_q <= re_ni;
    end
  end

  assign we_rise    = ~we_q & we_ni & ~ce_ni;
  assign cmd_stb_o  = we_rise & cle_i & ~ale_i;
  assign addr_stb_o = we_rise & ale_i & ~cle_i;
  assign data_stb_o = we_rise & ~cle_i & ~ale_i;
  assign rd_stb_o   = re_q & ~re_ni & ~ce_ni;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          busy_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R11
  busy_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array
  import nand_tgt_pkg::*;
#(
  parameter int MAIN_BYTES      = 64,
  parameter int SPARE_BYTES     = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_BLOCKS      = 4,
  localparam int PAGE_B = MAIN_BYTES + SPARE_BYTES,
  localparam int PG_W   = $clog2(PAGES_PER_BLOCK),
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int BLK_B  = PAGES_PER_BLOCK * PAGE_B,
  localparam int WORDS  = NUM_BLOCKS * BLK_B,
  localparam int NPG    = NUM_BLOCKS * PAGES_PER_BLOCK
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  arr_op_e               op_i,
  input  logic [BLK_W-1:0]      blk_i,
  input  logic [PG_W-1:0]       pg_i,
  input  logic [PAGE_B*8-1:0]   wr_page_i,
  output logic [PAGE_B*8-1:0]   rd_page_o,
  output logic                  refuse_o
);
  logic [WORDS*8-1:0] mem_q;
  logic [NPG*3-1:0]   pp_cnt_q;
  int pbase, bbase, cidx, er_base_q;
  logic bad_blk;
  logic [2:0] pp_cnt;

  always_comb begin
    pbase   = int'({blk_i, pg_i}) * PAGE_B;
    bbase   = int'(blk_i) * BLK_B;
    cidx    = int'({blk_i, pg_i}) * 3;
    bad_blk = mem_q[(bbase + MAIN_BYTES)*8 +: 8] != 8'hFF;
    pp_cnt  = pp_cnt_q[cidx +: 3];
    for (int b = 0; b < PAGE_B; b++) rd_page_o[b*8 +: 8] = mem_q[(pbase + b)*8 +: 8];
  end

  assign refuse_o = ((op_i == OP_PROG) && (bad_blk || pp_cnt >= 3'd4)) ||
                    ((op_i == OP_ERASE) && bad_blk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q     <= '1;
      pp_cnt_q  <= '0;
      er_base_q <= 0;
    end else if (!refuse_o) begin
      case (op_i)
        OP_PROG: begin
          for (int b = 0; b < PAGE_B; b++)
            mem_q[(pbase + b)*8 +: 8] <= mem_q[(pbase + b)*8 +: 8] & wr_page_i[b*8 +: 8];
          pp_cnt_q[cidx +: 3] <= pp_cnt + 3'd1;
        end
        OP_ERASE: begin
          for (int i = 0; i < BLK_B; i++) mem_q[(bbase + i)*8 +: 8] <= 8'hFF;
          for (int p = 0; p < PAGES_PER_BLOCK; p++) pp_cnt_q[(int'(blk_i)*PAGES_PER_BLOCK + p)*3 +: 3] <= 3'd0;
          er_base_q <= bbase;
        end
        default: ;
      endcase
    end
  end

  // R7
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ERASE && !refuse_o) |=>
      (mem_q[er_base_q*8 +: 8] == 8'hFF && mem_q[(er_base_q + BLK_B - 1)*8 +: 8] == 8'hFF));
endmodule

// File: rtl/nand_target_model.sv
module nand_target_model
  import nand_tgt_pkg::*;
#(
  parameter int MAIN_BYTES      = 64,
  parameter int SPARE_BYTES     = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_BLOCKS      = 4,
  parameter int T_READ          = 4,
  parameter int T_PROG          = 16,
  parameter int T_ERASE         = 24,
  parameter int T_RESET         = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_ni,
  input  logic       re_ni,
  input  logic [7:0] dq_i,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       rb_o
);
  localparam int PAGE_B = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W  = $clog2(PAGE_B);
  localparam int PG_W   = $clog2(PAGES_PER_BLOCK);
  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int RW     = PG_W + BLK_W;
  localparam int TW     = $clog2(T_READ + T_PROG + T_ERASE + T_RESET + 1);
  localparam logic [COL_W-1:0] LAST = COL_W'(PAGE_B - 1);

  logic cmd_stb, addr_stb, data_stb, rd_stb, busy, refuse, t_load;
  logic [TW-1:0] t_len;
  arr_op_e arr_op;
  seq_e state_q;
  logic [2:0] acnt_q;
  logic [7:0] col_lo_q, dq_q;
  logic [COL_W-1:0] col_q, pend_col_q;
  logic [RW-1:0] row_q;
  logic [PAGE_B*8-1:0] page_q, rd_page;
  logic stat_mode_q, fail_q;
  logic [7:0] status;

  function automatic logic [COL_W-1:0] clamp_col(input logic [15:0] c);
    return (c > 16'(PAGE_B - 1)) ? LAST : c[COL_W-1:0];
  endfunction

  function automatic logic [RW-1:0] row_put(input logic [RW-1:0] cur, input logic [7:0] b,
                                            input logic [1:0] k);
    logic [23:0] sh;
    sh = 24'(b) << {k, 3'b000};
    return (k == 2'd0) ? RW'(sh) : (cur | RW'(sh));
  endfunction

  nand_strobe_decode u_dec (
    .clk_i, .rst_ni, .ce_ni, .cle_i, .ale_i, .we_ni, .re_ni,
    .cmd_stb_o(cmd_stb), .addr_stb_o(addr_stb), .data_stb_o(data_stb), .rd_stb_o(rd_stb)
  );

  always_comb begin
    arr_op = OP_NONE;
    if (cmd_stb && !busy) begin
      if (dq_i == CMD_READ_GO && state_q == ST_RD_ADDR && acnt_q == 3'd5) arr_op = OP_READ;
      else if (dq_i == CMD_PROG_GO && state_q == ST_PG_DATA)               arr_op = OP_PROG;
      else if (dq_i == CMD_ERASE_GO && state_q == ST_ER_ADDR && acnt_q == 3'd3) arr_op = OP_ERASE;
    end
    t_load = (arr_op != OP_NONE) || (cmd_stb && dq_i == CMD_RESET);
    case (arr_op)
      OP_READ:  t_len = TW'(T_READ);
      OP_PROG:  t_len = TW'(T_PROG);
      OP_ERASE: t_len = TW'(T_ERASE);
      default:  t_len = TW'(T_RESET);
    endcase
  end

  nand_busy_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(t_load), .len_i(t_len), .busy_o(busy)
  );

  nand_cell_array #(
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .NUM_BLOCKS(NUM_BLOCKS)
  ) u_arr (
    .clk_i, .rst_ni, .op_i(arr_op),
    .blk_i(row_q[PG_W +: BLK_W]), .pg_i(row_q[PG_W-1:0]),
    .wr_page_i(page_q), .rd_page_o(rd_page), .refuse_o(refuse)
  );

  assign status = {1'b0, ~busy, 5'b0, fail_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      acnt_q      <= '0;
      col_lo_q    <= '0;
      col_q       <= '0;
      pend_col_q  <= '0;
      row_q       <= '0;
      page_q      <= '1;
      stat_mode_q <= 1'b0;
      fail_q      <= 1'b0;
      dq_q        <= '0;
    end else if (cmd_stb) begin
      if (dq_i == CMD_RESET) begin
        state_q     <= ST_IDLE;
        fail_q      <= 1'b0;
        stat_mode_q <= 1'b0;
      end else if (dq_i == CMD_STATUS) begin
        stat_mode_q <= 1'b1;
      end else if (!busy) begin
        stat_mode_q <= 1'b0;
        acnt_q      <= '0;
        case (dq_i)
          CMD_READ:  state_q <= ST_RD_ADDR;
          CMD_RCOL:  state_q <= ST_RC_ADDR;
          CMD_LOAD:  state_q <= ST_PG_ADDR;
          CMD_ERASE: state_q <= ST_ER_ADDR;
          CMD_LOAD_COL: if (state_q == ST_PG_DATA) state_q <= ST_RI_ADDR;
          CMD_READ_GO: if (arr_op == OP_READ) begin
            page_q  <= rd_page;
            col_q   <= pend_col_q;
            state_q <= ST_IDLE;
          end
          CMD_RCOL_GO: if (state_q == ST_RC_ADDR && acnt_q == 3'd2) begin
            col_q   <= pend_col_q;
            state_q <= ST_IDLE;
          end
          CMD_PROG_GO, CMD_ERASE_GO: if (arr_op != OP_NONE) begin
            fail_q  <= refuse;
            state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end else if (addr_stb && !busy) begin
      if (acnt_q != 3'd5) acnt_q <= acnt_q + 3'd1;
      case (state_q)
        ST_RD_ADDR, ST_PG_ADDR: begin
          case (acnt_q)
            3'd0: col_lo_q <= dq_i;
            3'd1: pend_col_q <= clamp_col({dq_i, col_lo_q});
            3'd2, 3'd3, 3'd4: row_q <= row_put(row_q, dq_i, 2'(acnt_q - 3'd2));
            default: ;
          endcase
          if (state_q == ST_PG_ADDR && acnt_q == 3'd4) begin
            state_q <= ST_PG_DATA;
            col_q   <= pend_col_q;
          end
        end
        ST_RC_ADDR, ST_RI_ADDR: begin
          if (acnt_q == 3'd0) col_lo_q <= dq_i;
          else if (acnt_q == 3'd1) begin
            pend_col_q <= clamp_col({dq_i, col_lo_q});
            if (state_q == ST_RI_ADDR) begin
              col_q   <= clamp_col({dq_i, col_lo_q});
              state_q <= ST_PG_DATA;
            end
          end
        end
        ST_ER_ADDR: if (acnt_q < 3'd3) row_q <= row_put(row_q, dq_i, acnt_q[1:0]);
        default: ;
      endcase
    end else if (data_stb && !busy && state_q == ST_PG_DATA) begin
      page_q[int'(col_q)*8 +: 8] <= dq_i;
      if (col_q != LAST) col_q <= col_q + 1'b1;
    end else if (rd_stb) begin
      if (stat_mode_q) dq_q <= status;
      else if (!busy) begin
        dq_q <= page_q[int'(col_q)*8 +: 8];
        if (col_q != LAST) col_q <= col_q + 1'b1;
      end
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = ~ce_ni & ~re_ni;
  assign rb_o    = ~busy;

  // R3
  col_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) col_q <= LAST);

  // R10
  status_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb && stat_mode_q && !cmd_stb) |=> dq_o == {1'b0, !$past(busy), 5'b0, $past(fail_q)});

  // R6
  lone_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb && dq_i == CMD_PROG_GO && state_q != ST_PG_DATA && !busy) |=> rb_o);

  // R12
  reset_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb && dq_i == CMD_RESET) |=> (!rb_o && !fail_q && state_q == ST_IDLE));
endmodule

// File: tb/nand_target_model_test.sv
module nand_target_model_test;
  localparam int MAIN = 16, SPARE = 4, PPB = 4, NBLK = 4;
  localparam int TRD = 3, TPG = 6, TER = 9, TRS = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] dq_in = '0, dq_out;
  logic dq_oe, rb;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event smp;

  always #2 clk = ~clk;

  nand_target_model #(
    .MAIN_BYTES(MAIN), .SPARE_BYTES(SPARE), .PAGES_PER_BLOCK(PPB), .NUM_BLOCKS(NBLK),
    .T_READ(TRD), .T_PROG(TPG), .T_ERASE(TER), .T_RESET(TRS)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe), .rb_o(rb)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as read strobes produce data
  always @(smp) begin
    if (exp_q.size() == 0) chk("scoreboard underrun", 1, 0);
    else chk(tag_q.pop_front(), int'(dq_out), int'(exp_q.pop_front()));
  end

  task automatic wr(logic c, logic a, logic [7:0] d);
    @(negedge clk); cle = c; ale = a; dq_in = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask
  task automatic cmd(logic [7:0] d); wr(1'b1, 1'b0, d); endtask
  task automatic dat(logic [7:0] d); wr(1'b0, 1'b0, d); endtask
  task automatic col2(int c); wr(1'b0, 1'b1, 8'(c)); wr(1'b0, 1'b1, 8'(c >> 8)); endtask
  task automatic row3(int r);
    wr(1'b0, 1'b1, 8'(r)); wr(1'b0, 1'b1, 8'(r >> 8)); wr(1'b0, 1'b1, 8'(r >> 16));
  endtask

  task automatic rd(logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); -> smp; re_n = 1'b1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!rb && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic page_read(int blk, int pg, int c);
    int n;
    cmd(8'h00); col2(c); row3(blk*PPB + pg); cmd(8'h30); busy_len(n);
  endtask
  task automatic status(logic [7:0] exp, string tag); cmd(8'h70); rd(exp, tag); endtask

  initial begin
    repeat (3000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 ready after reset", int'(rb), 1);
    chk("R13 bus not driven", int'(dq_oe), 0);
    status(8'h40, "R10 idle status");

    // R2 read of erased page, busy length
    cmd(8'h00); col2(0); row3(1*PPB + 2); cmd(8'h30); busy_len(n);
    chk("R11 read busy cycles", n, TRD);
    rd(8'hFF, "R13 erased cell"); rd(8'hFF, "R2 next column");

    // R5 sparse program with column move
    cmd(8'h80); col2(3); row3(1*PPB + 2); dat(8'hA5); dat(8'h3C); cmd(8'h10); busy_len(n);
    chk("R11 program busy cycles", n, TPG);
    status(8'h40, "R10 program pass");
    page_read(1, 2, 2);
    rd(8'hFF, "R2 col2"); rd(8'hA5, "R5 col3"); rd(8'h3C, "R5 col4"); rd(8'hFF, "R2 col5");

    // R5 unloaded bytes keep register contents (copy pg2 image into pg3)
    page_read(1, 2, 0);
    cmd(8'h80); col2(0); row3(1*PPB + 3); dat(8'h77); cmd(8'h10); busy_len(n);
    page_read(1, 3, 0);
    rd(8'h77, "R5 loaded byte"); rd(8'hFF, "R5 kept byte");
    rd(8'hFF, "R5 kept byte"); rd(8'hA5, "R5 kept register byte");

    // R5 program ANDs into cells (pg2 second program)
    cmd(8'h80); col2(3); row3(1*PPB + 2); dat(8'h0F); cmd(8'h10); busy_len(n);
    page_read(1, 2, 0);
    rd(8'h77, "R5 AND col0");
    // R4 random data output
    cmd(8'h05); col2(3); cmd(8'hE0);
    rd(8'h05, "R4 redirected column"); rd(8'h3C, "R4 continues");
    cmd(8'h05); col2(0); cmd(8'hE0);
    rd(8'h77, "R4 repeated redirect");

    // R5 random data input (85h)
    cmd(8'h80); col2(0); row3(2*PPB + 0); dat(8'h11); cmd(8'h85); col2(5); dat(8'h22); cmd(8'h10); busy_len(n);
    page_read(2, 0, 0);
    rd(8'h11, "R5 first load");
    cmd(8'h05); col2(5); cmd(8'hE0);
    rd(8'h22, "R5 85h load");

    // R3 last column holds
    cmd(8'h80); col2(18); row3(3*PPB + 1); dat(8'h12); dat(8'h34); cmd(8'h10); busy_len(n);
    page_read(3, 1, 18);
    rd(8'h12, "R3 col18"); rd(8'h34, "R3 last col"); rd(8'h34, "R3 repeat last");

    // R8 partial program limit on blk1 pg2 (two used)
    page_read(1, 2, 0);
    cmd(8'h80); col2(0); row3(1*PPB + 2); cmd(8'h10); busy_len(n);
    status(8'h40, "R8 third program");
    cmd(8'h80); col2(0); row3(1*PPB + 2); cmd(8'h10); busy_len(n);
    status(8'h40, "R8 fourth program");
    cmd(8'h80); col2(3); row3(1*PPB + 2); dat(8'h00); cmd(8'h10); busy_len(n);
    status(8'h41, "R8 fifth program fails");
    page_read(1, 2, 3);
    rd(8'h05, "R8 cells unchanged");

    // R7 erase, status during busy, counts cleared
    cmd(8'h60); row3(1*PPB); cmd(8'hD0);
    status(8'h00, "R10 status while busy");
    busy_len(n);
    chk("R11 erase busy remainder", n, TER - 5);
    status(8'h40, "R7 erase pass");
    page_read(1, 2, 3);
    rd(8'hFF, "R7 erased byte");
    cmd(8'h80); col2(0); row3(1*PPB + 2); dat(8'h5A); cmd(8'h10); busy_len(n);
    status(8'h40, "R7 count cleared");
    page_read(1, 2, 0);
    rd(8'h5A, "R7 reprogram");

    // R9 bad block marker
    cmd(8'h80); col2(MAIN); row3(3*PPB + 0); dat(8'h00); cmd(8'h10); busy_len(n);
    status(8'h40, "R9 marker write");
    cmd(8'h60); row3(3*PPB); cmd(8'hD0); busy_len(n);
    status(8'h41, "R9 erase refused");
    page_read(3, 1, 18);
    rd(8'h12, "R9 block kept");
    cmd(8'h80); col2(0); row3(3*PPB + 1); cmd(8'h10); busy_len(n);
    status(8'h41, "R9 program refused");

    // R12 reset clears fail
    cmd(8'hFF); busy_len(n);
    chk("R12 reset busy cycles", n, TRS);
    status(8'h40, "R12 fail cleared");

    // R6 lone confirm
    cmd(8'h10);
    chk("R6 no busy", int'(rb), 1);
    @(negedge clk);
    chk("R6 still ready", int'(rb), 1);

    // R1 chip enable high blocks capture
    ce_n = 1'b1; cmd(8'hFF);
    chk("R1 ignored while deselected", int'(rb), 1);
    ce_n = 1'b0;

    // R11 deselect during busy
    cmd(8'h60); row3(2*PPB); cmd(8'hD0);
    n = 0;
    while (!rb && n < 1000) begin
      if (n == 2) ce_n = 1'b1;
      n++; @(negedge clk);
    end
    ce_n = 1'b0;
    chk("R11 busy unaffected by deselect", n, TER);
    page_read(2, 0, 0);
    rd(8'hFF, "R11 erase completed");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule